// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two ways of leaving a trap handler: the "done" return, which resumes after the trapping instruction, and the "retry" return, which re-executes it. It holds a small stack of saved trap records, one per trap level. Each record has a saved program counter, a saved next program counter, a packed saved-state word and, when the hypervisor option is built in, a saved hypervisor-state value. The record for the current trap level is read combinationally. On a return request the block reloads the program counters and then unpacks the saved-state word into the condition codes, address space identifier, processor state, window pointer and global level. It then lowers the trap level by one.

The trap-entry path fills the stack through a plain write port and can set the trap level through a level-load port. The global register file lives elsewhere: this block only outputs the global level that selects a bank. Interrupt evaluation is also outside the block. A one-cycle recheck pulse tells the interrupt logic that a return has re-enabled interrupts.

Top module: `trap_return_unit`

## Requirements
- R1: A done return (`ret_kind` = 0) loads the program counter with the record's saved next-PC and loads the next-PC with the saved next-PC plus 4.
- R2: A retry return (`ret_kind` = 1) loads the program counter with the record's saved PC and loads the next-PC with the saved next-PC.
- R3: The condition-code byte is loaded from saved-state bits 39:32 and the address space identifier from bits 31:24; all other saved-state bits outside the fields of R3, R5, R6 and R7 are ignored.
- R4: In the condition-code byte, bit 0 is C, bit 1 is V, bit 2 is Z and bit 3 is N for the 32-bit result, and bits 7:4 carry the 64-bit flags in the same order. `icc_nzvc_o` and `xcc_nzvc_o` present each set as {N,Z,V,C}.
- R5: The processor state is loaded from saved-state bits 19:8 ANDed with 0xF3F, so bits 6 and 7 of the restored value are always 0.
- R6: The window pointer becomes WINDOWS-1-(F mod WINDOWS), where F is saved-state bits 7:0.
- R7: With the hypervisor option on, the global level is loaded from saved-state bits 42:40 and the hypervisor state from the record's saved hypervisor copy.
- R8: A return uses the record stored for the current trap level L (1..TL_LEVELS) and leaves the level at L-1. Records are written at level 1..TL_LEVELS through the write port. A write in the same cycle as a return takes effect after that return has read the old record.
- R9: A return request at trap level 0 raises `illegal_o` for one cycle and changes no other output.
- R10: All updates of a return commit on the clock edge after the request, and `done_o` is high for exactly the following cycle. Without a request, the program counters and restored fields hold.
- R11: `irq_recheck_o` pulses together with `done_o` exactly when the restored processor state has its interrupt-enable bit (bit 1) set.
- R12: A level load sets the trap level to the given value if that value is at most TL_LEVELS, and is ignored otherwise. A return request in the same cycle takes priority and the load is dropped.
- R13: While reset is asserted, the program counters and all restored fields read 0, the trap level reads TL_LEVELS, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Return request, one cycle |
| ret_kind | input | 1 | 0 = done return, 1 = retry return |
| lvl_wr_en | input | 1 | Load the trap level |
| lvl_wr_val | input | LVL_W | Trap level to load |
| stk_wr_en | input | 1 | Write a trap record |
| stk_wr_lvl | input | LVL_W | Level of the record to write |
| stk_wr_tpc | input | PC_W | Saved PC to write |
| stk_wr_tnpc | input | PC_W | Saved next-PC to write |
| stk_wr_tstate | input | TS_W | Saved-state word to write |
| stk_wr_hpstate | input | HPS_W | Saved hypervisor state to write |
| pc_o | output | PC_W | Program counter |
| npc_o | output | PC_W | Next program counter |
| ccr_o | output | 8 | Condition-code byte |
| icc_nzvc_o | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc_nzvc_o | output | 4 | 64-bit flags {N,Z,V,C} |
| asi_o | output | 8 | Address space identifier |
| pstate_o | output | 12 | Processor state |
| cwp_o | output | CWP_W | Window pointer |
| gl_o | output | 3 | Global level (bank select) |
| hpstate_o | output | HPS_W | Hypervisor state |
| tl_o | output | LVL_W | Trap level |
| done_o | output | 1 | Return committed |
| illegal_o | output | 1 | Return requested at level 0 |
| irq_recheck_o | output | 1 | Interrupts re-enabled, recheck |

## Verification
The bench aims at the level-0 request, where a design that forgot the guard would wrap the level to its maximum and load a record from nowhere. It also tries a level load issued together with a return: a wrong priority would leave the level at the loaded value instead of one below the old level. It rewrites a record in the very cycle that record is being restored, which exposes a design that forwards the new data. It also uses window fields at and above the window count, where a missing modulo or a missing reversal shows up as a wrong window pointer. Saved-state words with every bit set catch a processor-state mask that lets bits 6 and 7 through or a field taken from the wrong offset.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  typedef enum logic {
    RET_DONE  = 1'b0,
    RET_RETRY = 1'b1
  } ret_kind_e;

  localparam int CC_W   = 8;
  localparam int ASI_W  = 8;
  localparam int PST_W  = 12;
  localparam int GL_W   = 3;
  localparam int WINF_W = 8;

  localparam int CC_LSB  = 32;
  localparam int ASI_LSB = 24;
  localparam int PST_LSB = 8;
  localparam int WIN_LSB = 0;
  localparam int GL_LSB  = 40;

  localparam logic [PST_W-1:0] PST_KEEP = 12'hF3F;
  localparam int               PST_IE   = 1;

  typedef struct packed {
    logic [GL_W-1:0]  gl;
    logic [CC_W-1:0]  ccr;
    logic [ASI_W-1:0] asi;
    logic [PST_W-1:0] pstate;
  } restore_fields_t;

endpackage

// File: rtl/trap_stack_mem.sv
module trap_stack_mem #(
  parameter int   LEVELS = 6,
  parameter int   PC_W   = 64,
  parameter int   TS_W   = 48,
  parameter int   HPS_W  = 16,
  parameter bit   HAS_HV = 1'b1,
  localparam int  LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [PC_W-1:0]  wr_tpc,
  input  logic [PC_W-1:0]  wr_tnpc,
  input  logic [TS_W-1:0]  wr_tstate,
  input  logic [HPS_W-1:0] wr_hpstate,
  input  logic [LVL_W-1:0] rd_lvl,
  output logic [PC_W-1:0]  rd_tpc,
  output logic [PC_W-1:0]  rd_tnpc,
  output logic [TS_W-1:0]  rd_tstate,
  output logic [HPS_W-1:0] rd_hpstate
);

  logic [PC_W-1:0] tpc_q    [LEVELS];
  logic [PC_W-1:0] tnpc_q   [LEVELS];
  logic [TS_W-1:0] tstate_q [LEVELS];
  logic            wr_ok;

  // level 0 has no record; levels above LEVELS do not exist
  assign wr_ok = wr_en && (wr_lvl != '0) && (wr_lvl <= LVL_W'(LEVELS));

  for (genvar e = 0; e < LEVELS; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_ok && (wr_lvl == LVL_W'(e + 1))) begin
        tpc_q[e]    <= wr_tpc;
        tnpc_q[e]   <= wr_tnpc;
        tstate_q[e] <= wr_tstate;
      end
    end
  end

  always_comb begin
    rd_tpc    = '0;
    rd_tnpc   = '0;
    rd_tstate = '0;
    for (int e = 0; e < LEVELS; e++) begin
      if (rd_lvl == LVL_W'(e + 1)) begin
        rd_tpc    = tpc_q[e];
        rd_tnpc   = tnpc_q[e];
        rd_tstate = tstate_q[e];
      end
    end
  end

  if (HAS_HV) begin : g_hv
    logic [HPS_W-1:0] hps_q [LEVELS];

    for (genvar e = 0; e < LEVELS; e++) begin : g_hentry
      always_ff @(posedge clk) begin
        if (wr_ok && (wr_lvl == LVL_W'(e + 1))) begin
          hps_q[e] <= wr_hpstate;
        end
      end
    end

    always_comb begin
      rd_hpstate = '0;
      for (int e = 0; e < LEVELS; e++) begin
        if (rd_lvl == LVL_W'(e + 1)) rd_hpstate = hps_q[e];
      end
    end
  end else begin : g_nohv
    logic unused_hps;
    assign unused_hps = ^wr_hpstate;
    assign rd_hpstate = '0;
  end

endmodule

// File: rtl/tstate_unpack.sv
module tstate_unpack
  import trap_ret_pkg::*;
#(
  parameter int  PC_W    = 64,
  parameter int  TS_W    = 48,
  parameter int  WINDOWS = 8,
  localparam int CWP_W   = $clog2(WINDOWS)
) (
  input  ret_kind_e        kind,
  input  logic [PC_W-1:0]  tpc,
  input  logic [PC_W-1:0]  tnpc,
  input  logic [TS_W-1:0]  tstate,
  output logic [PC_W-1:0]  nxt_pc,
  output logic [PC_W-1:0]  nxt_npc,
  output restore_fields_t  flds,
  output logic [CWP_W-1:0] nxt_cwp
);

  localparam logic [PC_W-1:0]   INSN_BYTES = PC_W'(4);
  localparam logic [WINF_W-1:0] WIN_CNT    = WINF_W'(WINDOWS);
  localparam logic [CWP_W-1:0]  WIN_TOP    = CWP_W'(WINDOWS - 1);

  logic [WINF_W-1:0] win_field;
  logic [WINF_W-1:0] win_wrapped;
  logic              unused_bits;

  always_comb begin
    unique case (kind)
      RET_RETRY: begin
        nxt_pc  = tpc;
        nxt_npc = tnpc;
      end
      default: begin
        nxt_pc  = tnpc;
        nxt_npc = tnpc + INSN_BYTES;
      end
    endcase
  end

  assign flds.ccr    = tstate[CC_LSB +: CC_W];
  assign flds.asi    = tstate[ASI_LSB +: ASI_W];
  assign flds.pstate = tstate[PST_LSB +: PST_W] & PST_KEEP;
  assign flds.gl     = tstate[GL_LSB +: GL_W];

  // saved field counts windows in the opposite direction to the internal index
  assign win_field   = tstate[WIN_LSB +: WINF_W];
  assign win_wrapped = win_field % WIN_CNT;
  assign nxt_cwp     = WIN_TOP - CWP_W'(win_wrapped);

  assign unused_bits = ^{tstate[TS_W-1:GL_LSB+GL_W], tstate[ASI_LSB-1:PST_LSB+PST_W]};

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_ret_pkg::*;
#(
  parameter int  TL_LEVELS = 6,
  parameter int  WINDOWS   = 8,
  parameter int  PC_W      = 64,
  parameter int  TS_W      = 48,
  parameter int  HPS_W     = 16,
  parameter bit  HAS_HV    = 1'b1,
  localparam int LVL_W     = $clog2(TL_LEVELS + 1),
  localparam int CWP_W     = $clog2(WINDOWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_req,
  input  logic             ret_kind,
  input  logic             lvl_wr_en,
  input  logic [LVL_W-1:0] lvl_wr_val,
  input  logic             stk_wr_en,
  input  logic [LVL_W-1:0] stk_wr_lvl,
  input  logic [PC_W-1:0]  stk_wr_tpc,
  input  logic [PC_W-1:0]  stk_wr_tnpc,
  input  logic [TS_W-1:0]  stk_wr_tstate,
  input  logic [HPS_W-1:0] stk_wr_hpstate,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  output logic [7:0]       ccr_o,
  output logic [3:0]       icc_nzvc_o,
  output logic [3:0]       xcc_nzvc_o,
  output logic [7:0]       asi_o,
  output logic [11:0]      pstate_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [2:0]       gl_o,
  output logic [HPS_W-1:0] hpstate_o,
  output logic [LVL_W-1:0] tl_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             irq_recheck_o
);

  // current record
  logic [PC_W-1:0]  ent_tpc;
  logic [PC_W-1:0]  ent_tnpc;
  logic [TS_W-1:0]  ent_tstate;
  logic [HPS_W-1:0] ent_hpstate;

  // unpacked candidates
  logic [PC_W-1:0]  cand_pc;
  logic [PC_W-1:0]  cand_npc;
  restore_fields_t  cand_flds;
  logic [CWP_W-1:0] cand_cwp;

  // state
  logic [PC_W-1:0]  pc_q, npc_q;
  logic [CC_W-1:0]  ccr_q;
  logic [ASI_W-1:0] asi_q;
  logic [PST_W-1:0] pst_q;
  logic [CWP_W-1:0] cwp_q;
  logic [GL_W-1:0]  gl_q;
  logic [HPS_W-1:0] hps_q;
  logic [LVL_W-1:0] tl_q;
  logic             done_q, bad_q, rck_q;

  // next-state
  logic             commit;
  logic             at_floor;
  logic             tl_en;
  logic [LVL_W-1:0] tl_d;
  logic             done_d, bad_d, rck_d;

  trap_stack_mem #(
    .LEVELS (TL_LEVELS),
    .PC_W   (PC_W),
    .TS_W   (TS_W),
    .HPS_W  (HPS_W),
    .HAS_HV (HAS_HV)
  ) u_stack (
    .clk        (clk),
    .wr_en      (stk_wr_en),
    .wr_lvl     (stk_wr_lvl),
    .wr_tpc     (stk_wr_tpc),
    .wr_tnpc    (stk_wr_tnpc),
    .wr_tstate  (stk_wr_tstate),
    .wr_hpstate (stk_wr_hpstate),
    .rd_lvl     (tl_q),
    .rd_tpc     (ent_tpc),
    .rd_tnpc    (ent_tnpc),
    .rd_tstate  (ent_tstate),
    .rd_hpstate (ent_hpstate)
  );

  tstate_unpack #(
    .PC_W    (PC_W),
    .TS_W    (TS_W),
    .WINDOWS (WINDOWS)
  ) u_unpack (
    .kind    (ret_kind_e'(ret_kind)),
    .tpc     (ent_tpc),
    .tnpc    (ent_tnpc),
    .tstate  (ent_tstate),
    .nxt_pc  (cand_pc),
    .nxt_npc (cand_npc),
    .flds    (cand_flds),
    .nxt_cwp (cand_cwp)
  );

  always_comb begin
    at_floor = (tl_q == '0);
    commit   = ret_req && !at_floor;
    bad_d    = ret_req && at_floor;
    done_d   = commit;
    rck_d    = commit && cand_flds.pstate[PST_IE];
    tl_en    = 1'b0;
    tl_d     = tl_q;
    if (commit) begin
      tl_en = 1'b1;
      tl_d  = tl_q - 1'b1;
    end else if (!ret_req && lvl_wr_en && (lvl_wr_val <= LVL_W'(TL_LEVELS))) begin
      tl_en = 1'b1;
      tl_d  = lvl_wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      npc_q <= '0;
      ccr_q <= '0;
      asi_q <= '0;
      pst_q <= '0;
      cwp_q <= '0;
    end else if (commit) begin
      pc_q  <= cand_pc;
      npc_q <= cand_npc;
      ccr_q <= cand_flds.ccr;
      asi_q <= cand_flds.asi;
      pst_q <= cand_flds.pstate;
      cwp_q <= cand_cwp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q <= LVL_W'(TL_LEVELS);
    end else if (tl_en) begin
      tl_q <= tl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      rck_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      bad_q  <= bad_d;
      rck_q  <= rck_d;
    end
  end

  if (HAS_HV) begin : g_hv_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gl_q  <= '0;
        hps_q <= '0;
      end else if (commit) begin
        gl_q  <= cand_flds.gl;
        hps_q <= ent_hpstate;
      end
    end
  end else begin : g_no_hv_regs
    logic unused_hv;
    assign unused_hv = ^{cand_flds.gl, ent_hpstate};
    assign gl_q  = '0;
    assign hps_q = '0;
  end

  assign pc_o          = pc_q;
  assign npc_o         = npc_q;
  assign ccr_o         = ccr_q;
  assign icc_nzvc_o    = {ccr_q[3], ccr_q[2], ccr_q[1], ccr_q[0]};
  assign xcc_nzvc_o    = {ccr_q[7], ccr_q[6], ccr_q[5], ccr_q[4]};
  assign asi_o         = asi_q;
  assign pstate_o      = pst_q;
  assign cwp_o         = cwp_q;
  assign gl_o          = gl_q;
  assign hpstate_o     = hps_q;
  assign tl_o          = tl_q;
  assign done_o        = done_q;
  assign illegal_o     = bad_q;
  assign irq_recheck_o = rck_q;

endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk #(
  parameter int PC_W    = 64,
  parameter int TS_W    = 48,
  parameter int WINDOWS = 8,
  parameter int LVL_W   = 3,
  parameter int CWP_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_req,
  input logic             ret_kind,
  input logic [PC_W-1:0]  ent_tpc,
  input logic [PC_W-1:0]  ent_tnpc,
  input logic [TS_W-1:0]  ent_tstate,
  input logic [PC_W-1:0]  pc_o,
  input logic [PC_W-1:0]  npc_o,
  input logic [11:0]      pstate_o,
  input logic [CWP_W-1:0] cwp_o,
  input logic [LVL_W-1:0] tl_o,
  input logic             done_o,
  input logic             illegal_o,
  input logic             irq_recheck_o
);

  localparam logic [PC_W-1:0]  STEP  = PC_W'(4);
  localparam logic [7:0]       WCNT  = 8'(WINDOWS);
  localparam logic [CWP_W-1:0] WTOP  = CWP_W'(WINDOWS - 1);

  assert_done_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !ret_kind && tl_o != '0) |=>
      (pc_o == $past(ent_tnpc) && npc_o == $past(ent_tnpc) + STEP));

  assert_retry_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_kind && tl_o != '0) |=>
      (pc_o == $past(ent_tpc) && npc_o == $past(ent_tnpc)));

  assert_pstate_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pstate_o[7:6] == 2'b00);

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && tl_o != '0) |=>
      (cwp_o == WTOP - CWP_W'($past(ent_tstate[7:0]) % WCNT)));

  assert_level_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && tl_o != '0) |=> (done_o && tl_o == $past(tl_o) - 1'b1));

  assert_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && tl_o == '0) |=>
      (illegal_o && !done_o && $stable(pc_o) && $stable(npc_o) && $stable(tl_o)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> (!done_o && !illegal_o && $stable(pc_o) && $stable(npc_o) && $stable(cwp_o)));

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, illegal_o}));

  assert_recheck_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck_o |-> (done_o && pstate_o[1]));

endmodule

bind trap_return_unit trap_return_chk #(
  .PC_W    (PC_W),
  .TS_W    (TS_W),
  .WINDOWS (WINDOWS),
  .LVL_W   (LVL_W),
  .CWP_W   (CWP_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_req       (ret_req),
  .ret_kind      (ret_kind),
  .ent_tpc       (ent_tpc),
  .ent_tnpc      (ent_tnpc),
  .ent_tstate    (ent_tstate),
  .pc_o          (pc_o),
  .npc_o         (npc_o),
  .pstate_o      (pstate_o),
  .cwp_o         (cwp_o),
  .tl_o          (tl_o),
  .done_o        (done_o),
  .illegal_o     (illegal_o),
  .irq_recheck_o (irq_recheck_o)
);

// File: tb/test_trap_return_unit.sv
`timescale 1ns/1ps
module test_trap_return_unit;

  localparam int TLV   = 6;
  localparam int NWIN  = 8;
  localparam int PCW   = 64;
  localparam int TSW   = 48;
  localparam int HPSW  = 16;
  localparam int LW    = 3;
  localparam int CW    = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ret_req = 1'b0;
  logic            ret_kind = 1'b0;
  logic            lvl_wr_en = 1'b0;
  logic [LW-1:0]   lvl_wr_val = '0;
  logic            stk_wr_en = 1'b0;
  logic [LW-1:0]   stk_wr_lvl = '0;
  logic [PCW-1:0]  stk_wr_tpc = '0;
  logic [PCW-1:0]  stk_wr_tnpc = '0;
  logic [TSW-1:0]  stk_wr_tstate = '0;
  logic [HPSW-1:0] stk_wr_hpstate = '0;

  logic [PCW-1:0]  pc_o, npc_o;
  logic [7:0]      ccr_o, asi_o;
  logic [3:0]      icc_nzvc_o, xcc_nzvc_o;
  logic [11:0]     pstate_o;
  logic [CW-1:0]   cwp_o;
  logic [2:0]      gl_o;
  logic [HPSW-1:0] hpstate_o;
  logic [LW-1:0]   tl_o;
  logic            done_o, illegal_o, irq_recheck_o;

  always #2 clk = ~clk;

  trap_return_unit i_trap_return_unit (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_kind(ret_kind),
    .lvl_wr_en(lvl_wr_en), .lvl_wr_val(lvl_wr_val),
    .stk_wr_en(stk_wr_en), .stk_wr_lvl(stk_wr_lvl), .stk_wr_tpc(stk_wr_tpc),
    .stk_wr_tnpc(stk_wr_tnpc), .stk_wr_tstate(stk_wr_tstate), .stk_wr_hpstate(stk_wr_hpstate),
    .pc_o(pc_o), .npc_o(npc_o), .ccr_o(ccr_o), .icc_nzvc_o(icc_nzvc_o),
    .xcc_nzvc_o(xcc_nzvc_o), .asi_o(asi_o), .pstate_o(pstate_o), .cwp_o(cwp_o),
    .gl_o(gl_o), .hpstate_o(hpstate_o), .tl_o(tl_o), .done_o(done_o),
    .illegal_o(illegal_o), .irq_recheck_o(irq_recheck_o)
  );

  // reference model
  logic [PCW-1:0]  r_tpc   [0:TLV];
  logic [PCW-1:0]  r_tnpc  [0:TLV];
  logic [TSW-1:0]  r_ts    [0:TLV];
  logic [HPSW-1:0] r_hps   [0:TLV];
  logic [PCW-1:0]  m_pc, m_npc;
  logic [7:0]      m_ccr, m_asi;
  logic [11:0]     m_pst;
  int              m_cwp, m_gl, m_tl;
  logic [HPSW-1:0] m_hps;
  logic            m_done, m_ill, m_rck;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = '0; m_npc = '0; m_ccr = '0; m_asi = '0; m_pst = '0;
      m_cwp = 0; m_gl = 0; m_hps = '0; m_tl = TLV;
      m_done = 0; m_ill = 0; m_rck = 0;
    end else begin
      logic [TSW-1:0] st;
      int lv;
      m_done = 0; m_ill = 0; m_rck = 0;
      if (ret_req) begin
        if (m_tl == 0) m_ill = 1;
        else begin
          st = r_ts[m_tl];
          if (ret_kind) begin m_pc = r_tpc[m_tl]; m_npc = r_tnpc[m_tl]; end
          else begin m_pc = r_tnpc[m_tl]; m_npc = r_tnpc[m_tl] + 64'd4; end
          m_ccr = st[39:32];
          m_asi = st[31:24];
          m_pst = st[19:8] & 12'hF3F;
          m_cwp = NWIN - 1 - (int'(st[7:0]) % NWIN);
          m_gl  = int'(st[42:40]);
          m_hps = r_hps[m_tl];
          m_tl  = m_tl - 1;
          m_done = 1;
          m_rck = m_pst[1];
        end
      end else if (lvl_wr_en && int'(lvl_wr_val) <= TLV) begin
        m_tl = int'(lvl_wr_val);
      end
      lv = int'(stk_wr_lvl);
      if (stk_wr_en && lv >= 1 && lv <= TLV) begin
        r_tpc[lv] = stk_wr_tpc; r_tnpc[lv] = stk_wr_tnpc;
        r_ts[lv] = stk_wr_tstate; r_hps[lv] = stk_wr_hpstate;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(rst_n ? "R1 R2" : "R13", "pc", pc_o, m_pc);
      chk(rst_n ? "R1 R2" : "R13", "npc", npc_o, m_npc);
      chk("R3", "ccr", 64'(ccr_o), 64'(m_ccr));
      chk("R3", "asi", 64'(asi_o), 64'(m_asi));
      chk("R4", "icc", 64'(icc_nzvc_o), 64'({m_ccr[3], m_ccr[2], m_ccr[1], m_ccr[0]}));
      chk("R4", "xcc", 64'(xcc_nzvc_o), 64'({m_ccr[7], m_ccr[6], m_ccr[5], m_ccr[4]}));
      chk("R5", "pstate", 64'(pstate_o), 64'(m_pst));
      chk("R6", "cwp", 64'(cwp_o), 64'(m_cwp));
      chk("R7", "gl", 64'(gl_o), 64'(m_gl));
      chk("R7", "hpstate", 64'(hpstate_o), 64'(m_hps));
      chk("R8 R12", "tl", 64'(tl_o), 64'(m_tl));
      chk("R10", "done", 64'(done_o), 64'(m_done));
      chk("R9", "illegal", 64'(illegal_o), 64'(m_ill));
      chk("R11", "recheck", 64'(irq_recheck_o), 64'(m_rck));
    end
  end

  task automatic step(input bit rq, input bit kd, input bit le, input int lval);
    @(negedge clk);
    ret_req = rq; ret_kind = kd; lvl_wr_en = le; lvl_wr_val = LW'(lval);
    stk_wr_en = 1'b0;
  endtask

  task automatic put(input int lv, input logic [TSW-1:0] ts);
    @(negedge clk);
    ret_req = 1'b0; lvl_wr_en = 1'b0;
    stk_wr_en = 1'b1; stk_wr_lvl = LW'(lv);
    stk_wr_tpc = {$urandom(), $urandom()};
    stk_wr_tnpc = {$urandom(), $urandom()};
    stk_wr_tstate = ts;
    stk_wr_hpstate = HPSW'($urandom());
  endtask

  function automatic logic [TSW-1:0] rnd_ts();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (3) @(negedge clk);          // R13 reset values compared here
    rst_n = 1'b1;
    put(6, {TSW{1'b1}});                // all ones: mask R5, window field 255 for R6
    put(5, 48'h0000_0000_0208);         // window field 8 = WINDOWS, IE set
    for (int l = 1; l <= 4; l++) put(l, rnd_ts());
    put(4, {5'h1F, 3'd5, 8'hA5, 8'h3C, 4'hF, 12'h0C2, 8'd7});
    step(1, 0, 0, 0);                   // R1 done at level 6
    step(0, 0, 0, 0);                   // R10 hold
    step(1, 1, 0, 0);                   // R2 retry at level 5
    step(1, 0, 0, 0);                   // back to back, level 4
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);                   // level 1 -> 0
    step(1, 0, 0, 0);                   // R9 at level 0
    step(1, 1, 0, 0);                   // R9 again
    step(0, 0, 1, 7);                   // R12 out-of-range load ignored
    step(0, 0, 1, 2);                   // R12 load 2
    step(1, 1, 1, 5);                   // R12 request wins -> level 1
    step(0, 0, 1, 1);
    // R8 overwrite level 1 while restoring it
    @(negedge clk);
    ret_req = 1'b1; ret_kind = 1'b0; lvl_wr_en = 1'b0;
    stk_wr_en = 1'b1; stk_wr_lvl = LW'(1);
    stk_wr_tpc = 64'h1111; stk_wr_tnpc = 64'h2222;
    stk_wr_tstate = rnd_ts(); stk_wr_hpstate = 16'h3333;
    step(0, 0, 1, 1);
    step(1, 1, 0, 0);                   // restores the new level 1 record
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      ret_req = ($urandom_range(0, 9) < 4);
      ret_kind = $urandom_range(0, 1);
      lvl_wr_en = ($urandom_range(0, 9) < 2);
      lvl_wr_val = LW'($urandom_range(0, 7));
      stk_wr_en = ($urandom_range(0, 9) < 4);
      stk_wr_lvl = LW'($urandom_range(0, 7));
      stk_wr_tpc = {$urandom(), $urandom()};
      stk_wr_tnpc = {$urandom(), $urandom()};
      stk_wr_tstate = rnd_ts();
      stk_wr_hpstate = HPSW'($urandom());
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule